// File: doc/BRIEF.md
# Phase-Lock Detector with Consecutive-Pass Qualification

This block decides whether a phase-locked loop has settled. It watches two divider outputs: the divided reference and the divided feedback (RF) signal. Both are levels, synchronous to a fast sampling clock. A new comparison starts on each rising edge of either divider. The block counts sampling-clock cycles until the other divider rises. A comparison passes when that gap is shorter than `WINDOW_CYC` cycles. With the defaults (64 MHz sampling, 16 cycles) the window is about 250 ns.

A run counter tracks consecutive passing comparisons. The lock flag is raised once the run reaches `PASS_RUN`, which defaults to 7. A single failing comparison clears both the run and the flag.

A two-bit mode input can switch detection off. While it is off, the flag is held low and all history is discarded.

The comparison state machine has three states:
- `ST_IDLE`: no comparison is open.
- `ST_WAIT_FB`: the reference edge came first and the block is waiting for a feedback edge.
- `ST_WAIT_REF`: the feedback edge came first and the block is waiting for a reference edge.

Its transitions are named as follows:
- *open*: `ST_IDLE` to a wait state, on a single leading edge.
- *coincide*: `ST_IDLE` to `ST_IDLE`, when both edges arrive in the same cycle. This is a pass with a gap of 0.
- *close*: a wait state to `ST_IDLE`, when the partner edge arrives.
- *close-and-reopen*: a wait state to the same wait state, when the partner edge and a new leading edge arrive together.
- *restart*: a wait state to the same wait state, when the leading edge repeats. This is a failure.
- *timeout*: a wait state to `ST_IDLE`, when no partner arrives within `PERIOD_CYC` cycles. This is a failure.
- *disable*: any state to `ST_IDLE`, when detection is switched off.

Top module: `lockdet_top`

## Requirements
- R1: After reset, `lock` is 0. `PASS_RUN` passing comparisons are needed before it can rise.
- R2: A comparison passes when the partner edge is sampled g cycles after the leading edge, with g < `WINDOW_CYC`. It fails when g >= `WINDOW_CYC`.
- R3: Either divider may lead, and the same window applies in both orders. Edges sampled in the same cycle form a passing comparison with g = 0.
- R4: `lock` rises only after the `PASS_RUN`-th consecutive pass, and no earlier. It is high two clock edges after the partner edge that completed the run is sampled.
- R5: Any failing comparison clears the consecutive-pass count and drops `lock` within two clock edges.
- R6: If no partner edge arrives within `PERIOD_CYC` cycles of a leading edge, that comparison fails.
- R7: A repeat of the leading edge before its partner arrives is a failure. The gap for the next comparison is then measured from the repeated edge.
- R8: The mode code `mode = 2'b10` (bit 1 high, bit 0 low) disables detection. `lock` goes low in the same cycle, the count is cleared, and divider edges have no effect until another code is applied.
- R9: The mode codes 2'b00, 2'b01 and 2'b11 all leave detection active.
- R10: While passes continue, `lock` stays high. The run count saturates at `PASS_RUN`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_div | input | 1 | Divided reference signal (level) |
| fb_div | input | 1 | Divided feedback signal (level) |
| mode | input | 2 | Control code; 2'b10 disables detection |
| lock | output | 1 | High when phase lock is declared |

## Verification
The bench sweeps the gap across the whole window in both edge orders. It pays particular attention to gaps of `WINDOW_CYC`-1 and `WINDOW_CYC`: an off-by-one comparison would pass the second or fail the first. It counts passes up to the run length and checks the flag after every pass. A counter that trips at six passes, or never saturates, shows up there.

A lone leading edge must time out and clear lock; a design that waits forever would keep the flag high. A repeated leading edge is followed by a partner that is in the window only when measured from the repeat. A design that keeps the first timestamp therefore needs one pass too many. Finally, the bench toggles the disable code mid-lock and sends edges while disabled. It then checks that the flag drops at once, and that a full run is needed after the code is released.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_FB  = 2'd1,
        ST_WAIT_REF = 2'd2
    } cmp_state_e;

    localparam logic [1:0] MODE_OFF = 2'b10;
endpackage

// File: rtl/lockdet_rise.sv
module lockdet_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    assign rise = sig && !prev_q;
endmodule

// File: rtl/lockdet_cmp_fsm.sv
module lockdet_cmp_fsm
    import lockdet_pkg::*;
#(
    parameter int WINDOW_CYC = 16,
    parameter int PERIOD_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic cmp_pass,
    output logic cmp_fail
);
    localparam int CW = $clog2(PERIOD_CYC + 1);
    localparam logic [CW-1:0] WIN_LIM = CW'(WINDOW_CYC);
    localparam logic [CW-1:0] PER_LIM = CW'(PERIOD_CYC);

    cmp_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          pass_d, fail_d;
    logic          lead, part;

    always_comb begin
        lead = (state_q == ST_WAIT_FB) ? ref_rise : fb_rise;
        part = (state_q == ST_WAIT_FB) ? fb_rise  : ref_rise;
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pass_d  = 1'b0;
        fail_d  = 1'b0;
        if (!enable) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (ref_rise && fb_rise) begin
                        pass_d = 1'b1;
                    end else if (ref_rise) begin
                        state_d = ST_WAIT_FB;
                        cnt_d   = CW'(1);
                    end else if (fb_rise) begin
                        state_d = ST_WAIT_REF;
                        cnt_d   = CW'(1);
                    end
                end
                ST_WAIT_FB, ST_WAIT_REF: begin
                    if (part) begin
                        if (cnt_q < WIN_LIM) pass_d = 1'b1;
                        else                 fail_d = 1'b1;
                        if (lead) begin
                            cnt_d = CW'(1);
                        end else begin
                            state_d = ST_IDLE;
                            cnt_d   = '0;
                        end
                    end else if (lead) begin
                        fail_d = 1'b1;
                        cnt_d  = CW'(1);
                    end else if (cnt_q == PER_LIM) begin
                        fail_d  = 1'b1;
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_pass <= 1'b0;
            cmp_fail <= 1'b0;
        end else begin
            cmp_pass <= pass_d;
            cmp_fail <= fail_d;
        end
    end

    p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_pass && cmp_fail));

    p_late_fails_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_WAIT_FB && fb_rise && cnt_q >= WIN_LIM)
        |=> (cmp_fail && !cmp_pass));

    p_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q != ST_IDLE && cnt_q == PER_LIM && !ref_rise && !fb_rise)
        |=> cmp_fail);

    p_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_WAIT_FB && ref_rise && !fb_rise) |=> cmp_fail);

    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_q == ST_IDLE && !cmp_pass && !cmp_fail));
endmodule

// File: rtl/lockdet_run.sv
module lockdet_run #(
    parameter int PASS_RUN = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cmp_pass,
    input  logic cmp_fail,
    output logic lock
);
    localparam int RW = $clog2(PASS_RUN + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(PASS_RUN);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                run_q <= '0;
        else if (!enable)          run_q <= '0;
        else if (cmp_fail)         run_q <= '0;
        else if (cmp_pass && run_q != RUN_MAX) run_q <= run_q + RW'(1);
    end

    assign lock = enable && (run_q == RUN_MAX);

    p_fail_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_fail |=> (run_q == '0));

    p_grow_needs_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q > $past(run_q)) |-> $past(cmp_pass));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_MAX);

    p_off_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (run_q == '0));
endmodule

// File: rtl/lockdet_top.sv
module lockdet_top
    import lockdet_pkg::*;
#(
    parameter int WINDOW_CYC = 16,
    parameter int PERIOD_CYC = 125,
    parameter int PASS_RUN   = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_div,
    input  logic       fb_div,
    input  logic [1:0] mode,
    output logic       lock
);
    logic enable;
    logic ref_rise, fb_rise;
    logic cmp_pass, cmp_fail;

    assign enable = (mode != MODE_OFF);

    lockdet_rise u_ref_rise (.clk(clk), .rst_n(rst_n), .sig(ref_div), .rise(ref_rise));
    lockdet_rise u_fb_rise  (.clk(clk), .rst_n(rst_n), .sig(fb_div),  .rise(fb_rise));

    lockdet_cmp_fsm #(.WINDOW_CYC(WINDOW_CYC), .PERIOD_CYC(PERIOD_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .ref_rise(ref_rise), .fb_rise(fb_rise),
        .cmp_pass(cmp_pass), .cmp_fail(cmp_fail)
    );

    lockdet_run #(.PASS_RUN(PASS_RUN)) u_run (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cmp_pass(cmp_pass), .cmp_fail(cmp_fail), .lock(lock)
    );

    p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |=> ($past(mode) != MODE_OFF || !lock));
endmodule

// File: tb/tb_lockdet_top.sv
module tb_lockdet_top;
    localparam int W   = 16;
    localparam int PER = 125;
    localparam int RUN = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_div = 1'b0;
    logic       fb_div = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       lock;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_run = 0;
    bit en_model = 1'b1;

    always #4 clk = ~clk;

    lockdet_top #(.WINDOW_CYC(W), .PERIOD_CYC(PER), .PASS_RUN(RUN)) dut (
        .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .fb_div(fb_div),
        .mode(mode), .lock(lock)
    );

    task automatic check(input string tag, input logic exp);
        n_tests++;
        if (lock !== exp) begin
            n_fail++;
            $display("FAIL %s: lock=%b expected=%b", tag, lock, exp);
        end
    endtask

    // leader sampled at edge t0, partner at t0+g
    task automatic pair(input bit ref_first, input int g, input string tag);
        @(negedge clk);
        if (g == 0) begin ref_div = 1'b1; fb_div = 1'b1; end
        else if (ref_first) ref_div = 1'b1;
        else fb_div = 1'b1;
        for (int i = 0; i < g; i++) begin
            @(negedge clk);
            ref_div = 1'b0; fb_div = 1'b0;
            if (i == g - 1) begin
                if (ref_first) fb_div = 1'b1; else ref_div = 1'b1;
            end
        end
        @(negedge clk);
        ref_div = 1'b0; fb_div = 1'b0;
        repeat (10) @(negedge clk);
        if (en_model) begin
            if (g < W) exp_run = (exp_run < RUN) ? exp_run + 1 : RUN;
            else       exp_run = 0;
        end
        check(tag, en_model && exp_run == RUN);
    endtask

    task automatic build_lock(input string tag);
        for (int k = 0; k < RUN; k++) pair(k[0], k, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after reset", 1'b0);

        // R2/R3/R4: sweep gaps in both orders
        for (int ord = 0; ord < 2; ord++) begin
            for (int g = 0; g <= W + 2; g++) begin
                pair(ord == 0, g, ord == 0 ? "R2 ref-first sweep" : "R3 fb-first sweep");
            end
            build_lock("R4 run build");
            pair(ord == 0, W - 1, "R2 edge W-1 passes");
            pair(ord == 0, W, "R2 edge W fails");
        end

        // R4: lock not before the last pass, then R10 saturation
        for (int k = 0; k < RUN + 3; k++) pair(1'b1, 3, "R4/R10 count and hold");

        // R5: single failure
        pair(1'b0, W + 5, "R5 fail clears lock");

        // R6: missing partner
        build_lock("R6 prelock");
        @(negedge clk); ref_div = 1'b1;
        @(negedge clk); ref_div = 1'b0;
        repeat (PER + 10) @(negedge clk);
        exp_run = 0;
        check("R6 timeout clears", 1'b0);

        // R7: repeated leader restarts timing
        build_lock("R7 prelock");
        @(negedge clk); ref_div = 1'b1;
        @(negedge clk); ref_div = 1'b0;
        repeat (13) @(negedge clk);
        ref_div = 1'b1;
        @(negedge clk); ref_div = 1'b0;
        @(negedge clk);
        @(negedge clk); fb_div = 1'b1;
        @(negedge clk); fb_div = 1'b0;
        repeat (10) @(negedge clk);
        exp_run = 1;
        check("R7 repeat fails", 1'b0);
        for (int k = 0; k < RUN - 1; k++) pair(1'b0, 2, "R7 gap from repeat");

        // R8: disable code
        @(negedge clk); mode = 2'b10; en_model = 1'b0; exp_run = 0;
        #1 check("R8 same-cycle low", 1'b0);
        for (int k = 0; k < RUN + 1; k++) pair(1'b1, 1, "R8 ignored while off");
        @(negedge clk); mode = 2'b00; en_model = 1'b1;
        pair(1'b1, 1, "R8 history cleared");

        // R9: other codes keep detection active
        for (int m = 0; m < 4; m++) begin
            if (m != 2) begin
                @(negedge clk); mode = m[1:0];
                pair(1'b0, W, "R9 reset run");
                build_lock("R9 active code");
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: finished=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule